// File: doc/BRIEF.md
# Flow-Through Memory Copy Engine

A single-channel DMA engine that moves a block of words across a simple synchronous bus with no CPU involvement once the transfer starts. Software sets a source pointer, a destination pointer, a unit count and a mode word through a small register port, then sets a start bit. The engine requests the bus, waits for a grant, and moves each unit in two bus cycles. The first is a read from the source into an internal holding register. The second is a write of that register to the destination.

Each side can step through memory or stay fixed on a port address. This covers memory copy, memory-to-port and port-to-memory transfers. A port that is not always ready holds the current cycle with a ready input. A throttle can make the engine give the bus back for a set number of idle cycles after each group of units, so the CPU still gets its own cycles. Completion sets a sticky done flag, which can also drive an interrupt line.

Top module: `flow_dma`

## Requirements
- R1: Register map on `cfg_addr`: 0 source pointer, 1 destination pointer, 2 unit count, 3 mode (bit0 source fixed, bit1 destination fixed, bit2 interrupt enable), 4 control (bit0 start), 5 status (bit0 busy, bit1 done), 6 throttle (bits 7:0 units per burst, bits 15:8 gap cycles). With both mode bits clear, a start copies count words from source+i to destination+i.
- R2: With only mode bit1 set, unit i is read from source+i and written to the single destination address, in order.
- R3: With only mode bit0 set, every unit is read from the single source address and written to destination+i, in order.
- R4: Each unit takes exactly one completed read followed by one completed write. No read or write strobe is driven while `bus_gnt` is low, and read and write are never active together.
- R5: While `bus_rdy` is low, the active cycle is held with its strobe and address unchanged. It completes on the first clock edge with `bus_rdy` high.
- R6: With a nonzero burst value B and gap G≥1, after every B completed units that are not the last unit, `bus_req` stays low for exactly G cycles and is then raised again. A burst value of 0 disables the throttle.
- R7: A start with a count of 0 sets done and never raises `bus_req`.
- R8: Done is sticky. Writing status with bit1 set clears it, and writing bit1 as 0 leaves it set. `irq` equals done AND the interrupt-enable bit.
- R9: While busy, writes to the pointer, count, mode, throttle and control registers are ignored. The status busy bit reads 1 for the whole transfer.
- R10: The start bit reads back 0 once the engine has left idle.
- R11: After reset `bus_req`, `bus_rd`, `bus_wr` and `irq` are low and status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 32 | Write data from the holding register |
| bus_rdata | input | 32 | Read data |
| bus_rdy | input | 1 | Target ready; low stalls the cycle |

## Verification
The hardest case to reach is a throttle pause that overlaps a stall or a withdrawn grant. The gap count must stay exact while ready toggles at random and the grant disappears in the middle of a unit. The bench runs throttled transfers against a memory whose ready line is random. In a separate run it withholds the grant for a stretch while a unit is in flight. It measures every low stretch of the request line and the units between stretches. Writes to the registers while a transfer is running are made during a long randomly stalled transfer. Each one is followed by a readback, so the ignored values are seen at the register port.

// File: rtl/flow_dma_pkg.sv
package flow_dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_RD,
        ST_WR,
        ST_PAUSE
    } seq_state_e;

    localparam logic [2:0] REG_SRC   = 3'd0;
    localparam logic [2:0] REG_DST   = 3'd1;
    localparam logic [2:0] REG_LEN   = 3'd2;
    localparam logic [2:0] REG_MODE  = 3'd3;
    localparam logic [2:0] REG_CTRL  = 3'd4;
    localparam logic [2:0] REG_STAT  = 3'd5;
    localparam logic [2:0] REG_THR   = 3'd6;
endpackage

// File: rtl/flow_dma_regs.sv
module flow_dma_regs
    import flow_dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int LW = 16,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          busy,
    input  logic          start_clr,
    input  logic          done_set,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [LW-1:0] len,
    output logic          src_fix,
    output logic          dst_fix,
    output logic          start,
    output logic [TW-1:0] burst,
    output logic [TW-1:0] gap,
    output logic          irq
);
    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [LW-1:0] len;
        logic          sfix;
        logic          dfix;
        logic          ie;
        logic          start;
        logic          done;
        logic [TW-1:0] burst;
        logic [TW-1:0] gap;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  unused_wbits;
    assign unused_wbits = ^wdata;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            case (addr)
                REG_SRC:  if (!busy) regs_d.src = wdata[AW-1:0];
                REG_DST:  if (!busy) regs_d.dst = wdata[AW-1:0];
                REG_LEN:  if (!busy) regs_d.len = wdata[LW-1:0];
                REG_MODE: if (!busy) begin
                    regs_d.sfix = wdata[0];
                    regs_d.dfix = wdata[1];
                    regs_d.ie   = wdata[2];
                end
                REG_CTRL: if (!busy && wdata[0]) regs_d.start = 1'b1;
                REG_STAT: if (wdata[1]) regs_d.done = 1'b0;
                REG_THR:  if (!busy) begin
                    regs_d.burst = wdata[TW-1:0];
                    regs_d.gap   = wdata[2*TW-1:TW];
                end
                default: ;
            endcase
        end
        if (start_clr) regs_d.start = 1'b0;
        if (done_set)  regs_d.done  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            REG_SRC:  rdata = DW'(regs_q.src);
            REG_DST:  rdata = DW'(regs_q.dst);
            REG_LEN:  rdata = DW'(regs_q.len);
            REG_MODE: rdata = DW'({regs_q.ie, regs_q.dfix, regs_q.sfix});
            REG_CTRL: rdata = DW'(regs_q.start);
            REG_STAT: rdata = DW'({regs_q.done, busy});
            REG_THR:  rdata = DW'({regs_q.gap, regs_q.burst});
            default:  rdata = '0;
        endcase
    end

    assign src     = regs_q.src;
    assign dst     = regs_q.dst;
    assign len     = regs_q.len;
    assign src_fix = regs_q.sfix;
    assign dst_fix = regs_q.dfix;
    assign start   = regs_q.start;
    assign burst   = regs_q.burst;
    assign gap     = regs_q.gap;
    assign irq     = regs_q.done & regs_q.ie;

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.done && !(we && addr == REG_STAT && wdata[1]) |=> regs_q.done); // R8
    AST_LEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && we && addr == REG_LEN |=> $stable(regs_q.len)); // R9
    AST_START_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !regs_q.start); // R10
endmodule

// File: rtl/flow_dma_throttle.sv
module flow_dma_throttle #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] burst_cfg,
    input  logic [TW-1:0] gap_cfg,
    input  logic          busy,
    input  logic          clear,
    input  logic          unit_done,
    input  logic          pause_start,
    input  logic          in_pause,
    output logic          yield_now,
    output logic          gap_done
);
    typedef struct packed {
        logic [TW-1:0] burst_cnt;
        logic [TW-1:0] gap_cnt;
    } thr_t;

    thr_t thr_d, thr_q;

    assign yield_now = (burst_cfg != '0) && (thr_q.burst_cnt == burst_cfg - TW'(1));
    assign gap_done  = (thr_q.gap_cnt <= TW'(1));

    always_comb begin
        thr_d = thr_q;
        if (clear)
            thr_d.burst_cnt = '0;
        else if (unit_done)
            thr_d.burst_cnt = yield_now ? '0 : thr_q.burst_cnt + TW'(1);
        if (pause_start)
            thr_d.gap_cnt = gap_cfg;
        else if (in_pause && thr_q.gap_cnt != '0)
            thr_d.gap_cnt = thr_q.gap_cnt - TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) thr_q <= '0;
        else        thr_q <= thr_d;
    end

    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy && burst_cfg != '0 |-> thr_q.burst_cnt < burst_cfg); // R6
endmodule

// File: rtl/flow_dma_seq.sv
module flow_dma_seq
    import flow_dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src_cfg,
    input  logic [AW-1:0] dst_cfg,
    input  logic [LW-1:0] len_cfg,
    input  logic          src_fix,
    input  logic          dst_fix,
    input  logic          yield_now,
    input  logic          gap_done,
    output logic          busy,
    output logic          start_clr,
    output logic          done_set,
    output logic          unit_done,
    output logic          pause_start,
    output logic          in_pause,
    output logic          thr_clear,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_rdy
);
    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] sptr;
        logic [AW-1:0] dptr;
        logic [LW-1:0] remain;
        logic [DW-1:0] hold;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        start_clr   = 1'b0;
        done_set    = 1'b0;
        unit_done   = 1'b0;
        pause_start = 1'b0;
        in_pause    = 1'b0;
        thr_clear   = 1'b0;
        bus_req     = 1'b0;
        bus_rd      = 1'b0;
        bus_wr      = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    start_clr = 1'b1;
                    if (len_cfg == '0) begin
                        done_set = 1'b1;
                    end else begin
                        seq_d.sptr   = src_cfg;
                        seq_d.dptr   = dst_cfg;
                        seq_d.remain = len_cfg;
                        seq_d.st     = ST_ACQ;
                        thr_clear    = 1'b1;
                    end
                end
            end
            ST_ACQ: begin
                bus_req = 1'b1;
                if (bus_gnt) seq_d.st = ST_RD;
            end
            ST_RD: begin
                bus_req = 1'b1;
                bus_rd  = bus_gnt;
                if (bus_gnt && bus_rdy) begin
                    seq_d.hold = bus_rdata;
                    seq_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                bus_req = 1'b1;
                bus_wr  = bus_gnt;
                if (bus_gnt && bus_rdy) begin
                    unit_done = 1'b1;
                    if (!src_fix) seq_d.sptr = seq_q.sptr + AW'(1);
                    if (!dst_fix) seq_d.dptr = seq_q.dptr + AW'(1);
                    seq_d.remain = seq_q.remain - LW'(1);
                    if (seq_q.remain == LW'(1)) begin
                        done_set = 1'b1;
                        seq_d.st = ST_IDLE;
                    end else if (yield_now) begin
                        pause_start = 1'b1;
                        seq_d.st    = ST_PAUSE;
                    end else begin
                        seq_d.st = ST_RD;
                    end
                end
            end
            ST_PAUSE: begin
                in_pause = 1'b1;
                if (gap_done) seq_d.st = ST_ACQ;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign busy      = (seq_q.st != ST_IDLE);
    assign bus_addr  = (seq_q.st == ST_WR) ? seq_q.dptr : seq_q.sptr;
    assign bus_wdata = seq_q.hold;

    AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_rdy |=> !bus_rd); // R4
    AST_RD_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && !bus_rdy |=> $stable(bus_addr) && (bus_rd || !bus_gnt)); // R5
    AST_WR_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !bus_rdy |=> $stable(bus_addr) && $stable(bus_wdata)); // R5
    AST_ZERO_LEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.st == ST_IDLE && start && len_cfg == '0 |=> !bus_req); // R7
endmodule

// File: rtl/flow_dma.sv
module flow_dma
    import flow_dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int LW = 16,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    output logic          irq,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_rdy
);
    logic [AW-1:0] src, dst;
    logic [LW-1:0] len;
    logic [TW-1:0] burst, gap;
    logic          src_fix, dst_fix, start, busy;
    logic          start_clr, done_set, unit_done, pause_start, in_pause, thr_clear;
    logic          yield_now, gap_done;

    flow_dma_regs #(.AW(AW), .DW(DW), .LW(LW), .TW(TW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .busy(busy), .start_clr(start_clr), .done_set(done_set),
        .src(src), .dst(dst), .len(len), .src_fix(src_fix), .dst_fix(dst_fix),
        .start(start), .burst(burst), .gap(gap), .irq(irq)
    );

    flow_dma_throttle #(.TW(TW)) u_thr (
        .clk(clk), .rst_n(rst_n), .burst_cfg(burst), .gap_cfg(gap), .busy(busy),
        .clear(thr_clear), .unit_done(unit_done), .pause_start(pause_start),
        .in_pause(in_pause), .yield_now(yield_now), .gap_done(gap_done)
    );

    flow_dma_seq #(.AW(AW), .DW(DW), .LW(LW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .src_cfg(src), .dst_cfg(dst),
        .len_cfg(len), .src_fix(src_fix), .dst_fix(dst_fix), .yield_now(yield_now),
        .gap_done(gap_done), .busy(busy), .start_clr(start_clr), .done_set(done_set),
        .unit_done(unit_done), .pause_start(pause_start), .in_pause(in_pause),
        .thr_clear(thr_clear), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
    );

    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> !bus_rd && !bus_wr); // R4
endmodule

// File: tb/flow_dma_tb.sv
module flow_dma_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] PORT_IN  = 16'h00F0;
    localparam logic [15:0] PORT_OUT = 16'h00F8;
    localparam logic [31:0] PORT_BASE = 32'hA5C0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq, bus_req, bus_rd, bus_wr;
    logic        bus_gnt = 1'b0;
    logic        bus_rdy = 1'b1;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    flow_dma u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
    );

    typedef struct { logic [15:0] a; logic [31:0] d; } item_t;
    item_t exp_q[$];

    logic [31:0] mem [0:255];
    int  port_rd_cnt = 0;
    bit  port_adv = 0;
    bit  rnd_rdy = 0;
    bit  hold = 0;
    int  tests = 0, fails = 0;
    int  tot_rd = 0, tot_wr = 0, bad_strobe = 0, req_cycles = 0;
    int  exp_len = 0, exp_burst = 0, exp_gap = 0;
    int  low_run = 0, wr_in_burst = 0;
    bit  prev_req = 0;

    assign bus_rdata = (bus_addr == PORT_IN) ? PORT_BASE + 32'(port_rd_cnt) : mem[bus_addr[7:0]];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // bus responder and monitor: bench inputs change at the falling edge
    always @(negedge clk) begin
        if (port_adv) begin port_rd_cnt++; port_adv = 0; end
        bus_gnt = bus_req && !hold;
        bus_rdy = rnd_rdy ? ($urandom_range(0, 3) != 0) : 1'b1;
        #1;
        if ((bus_rd || bus_wr) && !bus_gnt) bad_strobe++;
        if (bus_rd && bus_wr) bad_strobe++;
        if (bus_req) req_cycles++;
        if (bus_rd && bus_rdy) begin
            tot_rd++;
            if (bus_addr == PORT_IN) port_adv = 1;
        end
        if (bus_wr && bus_rdy) begin
            tot_wr++;
            wr_in_burst++;
            if (bus_addr != PORT_OUT) mem[bus_addr[7:0]] = bus_wdata;
            if (exp_q.size() == 0) begin
                chk("R1 unexpected write", {16'h0, bus_addr}, 32'hFFFF_FFFF);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk("R1/R2/R3 write addr", {16'h0, bus_addr}, {16'h0, it.a});
                chk("R1/R2/R3 write data", bus_wdata, it.d);
            end
        end
        if (!bus_req) begin
            if (prev_req) begin
                if (exp_burst != 0 && tot_wr > 0 && tot_wr < exp_len)
                    chk("R6 units per burst", wr_in_burst, exp_burst);
                low_run = 0;
            end
            low_run++;
        end else if (!prev_req) begin
            if (exp_burst != 0 && tot_wr > 0 && tot_wr < exp_len)
                chk("R6 gap length", low_run, exp_gap);
            wr_in_burst = 0;
        end
        prev_req = bus_req;
    end

    task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #2;
        d = cfg_rdata;
    endtask

    task automatic start_xfer(input logic [15:0] src, input logic [15:0] dst, input int len,
                              input bit sfix, input bit dfix, input bit ie,
                              input int burst, input int gap, input bit rnd);
        cfg_wr(3'd0, {16'h0, src});
        cfg_wr(3'd1, {16'h0, dst});
        cfg_wr(3'd2, 32'(len));
        cfg_wr(3'd3, {29'h0, ie, dfix, sfix});
        cfg_wr(3'd6, {16'h0, 8'(gap), 8'(burst)});
        cfg_wr(3'd5, 32'h2);
        exp_q.delete();
        for (int i = 0; i < len; i++) begin
            item_t it;
            it.a = dfix ? dst : dst + 16'(i);
            it.d = sfix ? PORT_BASE + 32'(port_rd_cnt + i) : mem[8'(src + 16'(i))];
            exp_q.push_back(it);
        end
        tot_rd = 0; tot_wr = 0; bad_strobe = 0; req_cycles = 0;
        exp_len = len; exp_burst = burst; exp_gap = (gap == 0) ? 1 : gap;
        rnd_rdy = rnd;
        cfg_wr(3'd4, 32'h1);
    endtask

    task automatic finish_xfer(input string req);
        logic [31:0] st;
        st = '0;
        for (int i = 0; i < 3000; i++) begin
            cfg_rd(3'd5, st);
            if (st[1]) break;
        end
        chk({req, " done status"}, st, 32'h2);
        chk({req, " units read"}, tot_rd, exp_len);
        chk({req, " units written"}, tot_wr, exp_len);
        chk({req, " leftover items"}, exp_q.size(), 0);
        chk("R4 strobe without grant", bad_strobe, 0);
        rnd_rdy = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        for (int i = 0; i < 256; i++) mem[i] = $urandom();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        cfg_rd(3'd5, rv);
        chk("R11 status after reset", rv, 0);
        chk("R11 outputs after reset", {28'h0, bus_req, bus_rd, bus_wr, irq}, 0);

        // R1 memory copy, ready always high, interrupt enabled
        start_xfer(16'h0010, 16'h0040, 8, 0, 0, 1, 0, 0, 0);
        finish_xfer("R1");
        chk("R8 irq with enable", irq, 1);
        // R8 write-one-to-clear
        cfg_wr(3'd5, 32'h0);
        cfg_rd(3'd5, rv);
        chk("R8 done kept on zero write", rv[1], 1);
        cfg_wr(3'd5, 32'h2);
        cfg_rd(3'd5, rv);
        chk("R8 done cleared", rv[1], 0);
        chk("R8 irq after clear", irq, 0);

        // R2 memory to port, random ready (R5)
        start_xfer(16'h0060, PORT_OUT, 6, 0, 1, 0, 0, 0, 1);
        finish_xfer("R2");
        chk("R8 irq masked", irq, 0);
        cfg_wr(3'd3, 32'h4);
        chk("R8 irq after enable", irq, 1);

        // R3 port to memory, random ready (R5)
        start_xfer(PORT_IN, 16'h0080, 7, 1, 0, 0, 0, 0, 1);
        finish_xfer("R3");

        // R6 throttle: bursts of 3, gaps of 4
        start_xfer(16'h0090, 16'h00B0, 10, 0, 0, 0, 3, 4, 1);
        finish_xfer("R6");
        // R6 throttle: bursts of 2, gaps of 1
        start_xfer(16'h00C0, 16'h00D0, 5, 0, 0, 0, 2, 1, 0);
        finish_xfer("R6");

        // R7 zero count
        start_xfer(16'h0000, 16'h0020, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        cfg_rd(3'd5, rv);
        chk("R7 done on zero count", rv[1], 1);
        chk("R7 no bus request", req_cycles, 0);

        // R9 / R10 writes while busy
        start_xfer(16'h0020, 16'h0070, 12, 0, 0, 0, 2, 3, 1);
        cfg_rd(3'd4, rv);
        chk("R10 start self-clears", rv[0], 0);
        cfg_rd(3'd5, rv);
        chk("R9 busy reads 1", rv[0], 1);
        cfg_wr(3'd0, 32'h0000_1234);
        cfg_wr(3'd2, 32'h0000_0003);
        cfg_wr(3'd3, 32'h0000_0003);
        cfg_rd(3'd0, rv);
        chk("R9 source ignored while busy", rv, 32'h20);
        cfg_rd(3'd2, rv);
        chk("R9 count ignored while busy", rv, 12);
        cfg_rd(3'd3, rv);
        chk("R9 mode ignored while busy", rv, 0);
        finish_xfer("R9");

        // R4 grant withheld in the middle of a transfer
        start_xfer(16'h0030, 16'h00E0, 9, 0, 0, 0, 0, 0, 1);
        repeat (4) @(negedge clk);
        hold = 1;
        repeat (20) @(negedge clk);
        hold = 0;
        finish_xfer("R4");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule